// File: doc/BRIEF.md
# Slow-Clock System Timer with Absolute Alarm

This block is a system timer for a chip that has a slow timing reference of about 32 kHz. The reference arrives as a one-cycle tick enable in the main clock domain. A programmable divider scales the tick into increments of a free-running real-time counter. A comparator watches that counter for an absolute alarm value. A separate interval timer raises an event every programmed number of raw ticks.

All events are collected in a sticky status word, and reading that word clears it. An enable mask selects which status bits drive a single level-sensitive interrupt. Because the interrupt line may be shared, it stays high until software reads the status word. A small synchronous register bus, with one cycle of read latency, gives access to the divider, the alarm, the interval period, the counter, the status and the mask.

Software arms a one-shot delay by reading the counter, adding the delay, and writing the sum as the alarm. It gets a periodic tick by programming the interval period.

Top module: `sys_alarm_timer`

## Requirements
- R1: After reset the counter, status and mask read 0. The divider reads 32768. The alarm reads all ones over the counter width. `irq` is low.
- R2: The counter is `CNT_W` bits wide (default 20). It increases by exactly one per increment and wraps to 0 after its maximum. It never changes without `slow_tick`.
- R3: With divider value N of 2 or more, the counter advances once every N ticks. Values 0 and 1 advance it on every tick. Writing the divider restarts the divide phase.
- R4: Status bit 3 is set when the counter steps onto a value equal to the alarm register.
- R5: An alarm written with the counter's present value does not fire at once. It fires only after the counter has wrapped and steps onto that value again.
- R6: With interval period P of 1 or more, status bit 0 is set on every P-th tick. Writing the period restarts the interval count from zero. P = 0 stops the interval timer.
- R7: The status bits are: bit 0 interval expired, bit 1 watchdog overflow, bit 2 counter incremented, bit 3 alarm matched. Bit 1 always reads 0. Set bits stay set until the status word is read.
- R8: A status read returns the bits held before the read and clears them. An event in the same cycle as the read is kept set after the clear.
- R9: Writing the enable register (address 5) sets the mask bits where the data is 1. Writing the disable register (address 6) clears the mask bits where the data is 1. Zero bits leave the mask unchanged.
- R10: `irq` is the OR of the status bits ANDed with the mask. Once high, it stays high until the status word is read or the mask is cleared.
- R11: Word addresses are: 0 divider, 1 alarm, 2 period, 3 counter, 4 status, 5 enable, 6 disable, 7 mask. Read data appears on the cycle after the read strobe. Addresses 5 and 6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, masked OR of status |

## Verification
The hardest case to reach is an alarm armed at the present count, because it only fires after a full counter wrap. At the default width that is a million ticks. The bench instantiates a 12-bit counter with a divider of 1, so the wrap takes 4096 ticks. It then checks that the alarm bit is still clear one tick before the wrap and set one tick after. A second hard case is a status read that lands in the same cycle as an interval expiry. The bench times that read so that both happen on the same edge.

// File: rtl/sat_pkg.sv
package sat_pkg;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 32;
   localparam int NSTAT  = 4;

   localparam logic [ADDR_W-1:0] A_DIV    = 3'd0;
   localparam logic [ADDR_W-1:0] A_ALARM  = 3'd1;
   localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
   localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
   localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
   localparam logic [ADDR_W-1:0] A_IEN    = 3'd5;
   localparam logic [ADDR_W-1:0] A_IDIS   = 3'd6;
   localparam logic [ADDR_W-1:0] A_MASK   = 3'd7;

   localparam int S_IVL  = 0;
   localparam int S_WDOG = 1;
   localparam int S_INC  = 2;
   localparam int S_ALM  = 3;
endpackage

// File: rtl/sat_prescaler.sv
module sat_prescaler #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [PW-1:0] div,
   input  logic          restart,
   output logic          inc
);
   logic [PW-1:0] phase_q;
   logic          last;

   // divider values 0 and 1 both mean "every tick"
   assign last = (div <= PW'(1)) || (phase_q == div - PW'(1));
   assign inc  = tick && last;

   always_ff @(posedge clk) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else if (tick)    phase_q <= last ? '0 : phase_q + PW'(1);
   end
endmodule

// File: rtl/sat_rtc.sv
module sat_rtc #(
   parameter int CW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic [CW-1:0] alarm,
   output logic [CW-1:0] cnt,
   output logic          alm_hit
);
   logic [CW-1:0] cnt_nx;

   assign cnt_nx  = cnt + CW'(1);
   // match only on stepping onto the value, never on a standing equality
   assign alm_hit = inc && (cnt_nx == alarm);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt_nx;
   end
endmodule

// File: rtl/sat_interval.sv
module sat_interval #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [PER_W-1:0] period,
   input  logic             restart,
   output logic             expired
);
   logic [PER_W-1:0] n_q;
   logic             run;
   logic             wrap;

   assign run     = (period != '0);
   assign wrap    = (n_q == period - PER_W'(1));
   assign expired = tick && run && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n)            n_q <= '0;
      else if (restart)      n_q <= '0;
      else if (tick && run)  n_q <= wrap ? '0 : n_q + PER_W'(1);
   end
endmodule

// File: rtl/sat_status.sv
module sat_status #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         clr,
   input  logic [N-1:0] set_m,
   input  logic [N-1:0] clr_m,
   output logic [N-1:0] st,
   output logic [N-1:0] mask,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)   st[i] <= 1'b0;
         else if (clr) st[i] <= ev[i];          // event wins over read-clear
         else          st[i] <= st[i] | ev[i];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)        mask[i] <= 1'b0;
         else if (set_m[i]) mask[i] <= 1'b1;
         else if (clr_m[i]) mask[i] <= 1'b0;
      end
   end

   assign irq = |(st & mask);
endmodule

// File: rtl/sys_alarm_timer.sv
module sys_alarm_timer #(
   parameter int CNT_W     = 20,
   parameter int PRESC_W   = 16,
   parameter int PER_W     = 16,
   parameter int PRESC_RST = 32768
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        slow_tick,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);
   import sat_pkg::*;

   localparam int NS = NSTAT;
   localparam logic [CNT_W-1:0]   ALARM_RST = '1;
   localparam logic [PRESC_W-1:0] DIV_RST   = PRESC_W'(PRESC_RST);

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (PRESC_W < 1 || PRESC_W > DATA_W) begin : g_bad_presc
      $error("PRESC_W out of range");
   end
   if (PER_W < 1 || PER_W > DATA_W) begin : g_bad_per
      $error("PER_W out of range");
   end
   if (PRESC_RST < 0 || PRESC_RST >= (64'd1 << PRESC_W)) begin : g_bad_rst
      $error("PRESC_RST does not fit PRESC_W");
   end

   logic [PRESC_W-1:0] div_q;
   logic [CNT_W-1:0]   alarm_q;
   logic [PER_W-1:0]   period_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [NS-1:0]      st_q, mask_q, ev;
   logic               wr_stb, rd_stb;
   logic               inc, alm_hit, ivl_exp;
   logic               div_wr, per_wr, st_clr;
   logic [NS-1:0]      set_m, clr_m;
   logic [31:0]        rd_val;

   assign wr_stb = bus_sel && bus_wr;
   assign rd_stb = bus_sel && !bus_wr;
   assign div_wr = wr_stb && (bus_addr == A_DIV);
   assign per_wr = wr_stb && (bus_addr == A_PERIOD);
   assign st_clr = rd_stb && (bus_addr == A_STATUS);
   assign set_m  = (wr_stb && bus_addr == A_IEN)  ? bus_wdata[NS-1:0] : '0;
   assign clr_m  = (wr_stb && bus_addr == A_IDIS) ? bus_wdata[NS-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q    <= DIV_RST;
         alarm_q  <= ALARM_RST;
         period_q <= '0;
      end else begin
         if (div_wr)                               div_q    <= bus_wdata[PRESC_W-1:0];
         if (wr_stb && bus_addr == A_ALARM)        alarm_q  <= bus_wdata[CNT_W-1:0];
         if (per_wr)                               period_q <= bus_wdata[PER_W-1:0];
      end
   end

   sat_prescaler #(.PW(PRESC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick), .div(div_q),
      .restart(div_wr), .inc(inc));

   sat_rtc #(.CW(CNT_W)) u_rtc (
      .clk(clk), .rst_n(rst_n), .inc(inc), .alarm(alarm_q),
      .cnt(cnt_q), .alm_hit(alm_hit));

   sat_interval #(.PER_W(PER_W)) u_ivl (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick), .period(period_q),
      .restart(per_wr), .expired(ivl_exp));

   always_comb begin
      ev         = '0;
      ev[S_IVL]  = ivl_exp;
      ev[S_WDOG] = 1'b0;
      ev[S_INC]  = inc;
      ev[S_ALM]  = alm_hit;
   end

   sat_status #(.N(NS)) u_st (
      .clk(clk), .rst_n(rst_n), .ev(ev), .clr(st_clr),
      .set_m(set_m), .clr_m(clr_m), .st(st_q), .mask(mask_q), .irq(irq));

   always_comb begin
      rd_val = '0;
      case (bus_addr)
         A_DIV:    rd_val = 32'(div_q);
         A_ALARM:  rd_val = 32'(alarm_q);
         A_PERIOD: rd_val = 32'(period_q);
         A_COUNT:  rd_val = 32'(cnt_q);
         A_STATUS: rd_val = 32'(st_q);
         A_MASK:   rd_val = 32'(mask_q);
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_stb) bus_rdata <= rd_val;
   end
endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
   parameter int CW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          slow_tick,
   input logic          bus_sel,
   input logic          bus_wr,
   input logic [2:0]    bus_addr,
   input logic [31:0]   bus_wdata,
   input logic          irq,
   input logic [CW-1:0] cnt,
   input logic [3:0]    st,
   input logic [3:0]    mask
);
   logic st_rd, ien_wr, idis_wr;
   assign st_rd   = bus_sel && !bus_wr && bus_addr == 3'd4;
   assign ien_wr  = bus_sel && bus_wr && bus_addr == 3'd5;
   assign idis_wr = bus_sel && bus_wr && bus_addr == 3'd6;

   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !slow_tick |=> $stable(cnt));
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + CW'(1))));
   p_wdog_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !st[1]);
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !st_rd |=> ((st & $past(st)) == $past(st)));
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && !slow_tick) |=> (st == 4'd0));
   p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ien_wr |=> ((mask & $past(bus_wdata[3:0])) == $past(bus_wdata[3:0])));
   p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !st_rd && !idis_wr) |=> irq);
endmodule

bind sys_alarm_timer sat_checker #(.CW(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
   .cnt(cnt_q), .st(st_q), .mask(mask_q));

// File: tb/sys_alarm_timer_tb_top.sv
module sys_alarm_timer_tb_top;
   localparam int CLK_PER = 10;
   localparam int CW      = 12;
   localparam int CMASK   = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // reference state
   int m_div = 32768, m_pc = 0, m_cnt = 0, m_alarm = CMASK;
   int m_per = 0, m_pit = 0, m_st = 0, m_mask = 0, m_rd = 0;

   always #(CLK_PER/2) clk = ~clk;

   sys_alarm_timer #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq));

   function automatic int rd_model(int a);
      case (a)
         0: return m_div;
         1: return m_alarm;
         2: return m_per;
         3: return m_cnt;
         4: return m_st;
         7: return m_mask;
         default: return 0;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one bus/tick cycle, starting and ending at a falling edge
   task automatic step(bit s, bit w, int a, int d, bit t);
      int ev;
      bit inc;
      bus_sel = s; bus_wr = w; bus_addr = 3'(a); bus_wdata = d; slow_tick = t;
      if (s && !w) m_rd = rd_model(a);
      ev = 0;
      if (t) begin
         inc = (m_div <= 1) || (m_pc + 1 == m_div);
         m_pc = inc ? 0 : m_pc + 1;
         if (inc) begin
            m_cnt = (m_cnt + 1) & CMASK;
            ev |= 4;
            if (m_cnt == m_alarm) ev |= 8;
         end
         if (m_per != 0) begin
            if (m_pit + 1 == m_per) begin m_pit = 0; ev |= 1; end
            else m_pit++;
         end
      end
      if (s && w) begin
         case (a)
            0: begin m_div = d & 16'hFFFF; m_pc = 0; end
            1: m_alarm = d & CMASK;
            2: begin m_per = d & 16'hFFFF; m_pit = 0; end
            5: m_mask |= d & 4'hF;
            6: m_mask &= ~d & 4'hF;
            default: ;
         endcase
      end
      if (s && !w && a == 4) m_st = 0;
      m_st |= ev;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; slow_tick = 1'b0;
   endtask

   task automatic wr(int a, int d);
      step(1, 1, a, d, 0);
   endtask

   task automatic rd(int a, output int v);
      step(1, 0, a, 0, 0);
      v = int'(bus_rdata);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v, c;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", int'(irq), 0);
      rd(0, v); chk("R1 divider", v, 32768);
      rd(1, v); chk("R1 alarm", v, CMASK);
      rd(3, v); chk("R1 count", v, 0);
      rd(4, v); chk("R1 status", v, 0);
      rd(7, v); chk("R1 mask", v, 0);

      // R3 divide by 4, then phase restart on rewrite
      wr(0, 4);
      ticks(8);
      rd(3, v); chk("R3 div4 count", v, 2);
      ticks(3);
      wr(0, 4);
      ticks(3);
      rd(3, v); chk("R3 restart holds", v, 2);
      ticks(1);
      rd(3, v); chk("R3 restart step", v, 3);

      // R2 divide by 1 -> one step per tick
      wr(0, 1);
      ticks(5);
      rd(3, v); chk("R2 count", v, 8);

      // R7/R8 increment bit sticky, cleared by read
      rd(4, v); chk("R7 inc bit", v, 4);
      rd(4, v); chk("R8 cleared", v, 0);

      // R4 absolute alarm
      wr(1, 11);
      ticks(2);
      rd(4, v); chk("R4 not yet", v & 8, 0);
      ticks(1);
      rd(4, v); chk("R4 alarm hit", v, 12);

      // R10 masked interrupt, held until status read
      wr(5, 8);
      chk("R10 idle low", int'(irq), 0);
      wr(1, 13);
      ticks(2);
      chk("R10 irq rise", int'(irq), 1);
      step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
      chk("R10 irq held", int'(irq), 1);
      rd(4, v);
      chk("R10 irq cleared", int'(irq), 0);

      // R9 write-one set/clear
      wr(5, 1);  rd(7, v); chk("R9 set", v, 9);
      wr(5, 0);  rd(7, v); chk("R9 zero set", v, 9);
      wr(6, 8);  rd(7, v); chk("R9 clear", v, 1);
      wr(6, 0);  rd(7, v); chk("R9 zero clear", v, 1);
      wr(6, 1);  rd(7, v); chk("R9 clear all", v, 0);

      // R6 interval timer
      wr(2, 5);
      ticks(4);
      rd(4, v); chk("R6 before", v & 1, 0);
      ticks(1);
      rd(4, v); chk("R6 expired", v & 1, 1);
      ticks(3);
      wr(2, 5);
      ticks(3);
      rd(4, v); chk("R6 restart", v & 1, 0);
      ticks(2);
      rd(4, v); chk("R6 after restart", v & 1, 1);
      wr(2, 0);
      ticks(10);
      rd(4, v); chk("R6 disabled", v & 1, 0);

      // R8 event in the same cycle as the status read
      wr(2, 2);
      ticks(1);
      step(1, 0, 4, 0, 1);
      chk("R8 old value", int'(bus_rdata), 4);
      rd(4, v); chk("R8 event kept", v, 5);

      // R5 alarm at the present count waits a full wrap
      wr(2, 0);
      rd(4, v);
      rd(3, c);
      wr(1, c);
      ticks(CMASK);
      rd(4, v); chk("R5 no early fire", v & 8, 0);
      ticks(1);
      rd(4, v); chk("R5 fires after wrap", v & 8, 8);
      rd(3, v); chk("R2 wrapped count", v, c);

      // R11 write-only addresses read zero
      rd(5, v); chk("R11 ien reads 0", v, 0);
      rd(6, v); chk("R11 idis reads 0", v, 0);

      // random mix against the reference
      for (int i = 0; i < 600; i++) begin
         int r;
         r = int'($urandom % 10);
         case (r)
            0, 1, 2, 3, 4: step(0, 0, 0, 0, 1);
            5: begin
               rd(int'($urandom % 8), v);
               chk("R11 random read", v, m_rd);
            end
            6: wr(5, int'($urandom % 16));
            7: wr(6, int'($urandom % 16));
            8: wr(2, int'($urandom % 6));
            default: begin
               step(1, 0, 4, 0, ($urandom % 2) == 1);
               chk("R7 status/wdog", int'(bus_rdata), m_rd);
               chk("R7 wdog zero", int'(bus_rdata) & 2, 0);
            end
         endcase
         chk("R10 random irq", int'(irq), ((m_st & m_mask) != 0) ? 1 : 0);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule